// File: doc/BRIEF.md
# Oscillator Settling Timer

This block times how long a newly enabled oscillator needs to stabilise before the system clock may move onto it. Two 8-bit counter stages are chained into one 16-bit up-counter that advances once for every cycle of the selected source clock. The source clock arrives as a one-cycle enable, `srcTick`, in the system clock domain. Software loads a 16-bit compare value and raises the run control. When the count reaches the programmed value, the counter returns to zero, a one-cycle interrupt pulse is issued, and a sticky status flag is set.

Only the upper byte of the compare value takes part in the match, so the delay is a whole number of 256-tick steps. An upper byte of zero is treated as 256 steps, which means a zero-length delay cannot be programmed. With a 32.768 kHz source, 0x0100 gives roughly 7.81 ms and 0xFF00 roughly 1.99 s. The waveform output that the counter would otherwise drive is held low in this mode, so no stray pulses reach a pin. The same block serves either switching direction: the source enable comes from whichever oscillator is being brought up.

Top module: `osc_settle_top`

## Requirements
- R1: After reset, `irqPulse`, `doneFlag` and `wavePin` are 0 and `countOut` is 0.
- R2: While `runEn` is 0, `countOut` is held at 0 and `srcTick` has no effect on it.
- R3: While `runEn` is 1, `countOut` rises by exactly one on each clock edge where `srcTick` is 1 and does not change on edges where `srcTick` is 0.
- R4: With upper compare byte U (1..255), `irqPulse` is 1 in the cycle after the clock edge on which the U*256-th tick since start is taken, and `countOut` is 0 in that same cycle.
- R5: The lower byte of the compare value (`cmpWrData[7:0]`) has no effect on when the match occurs.
- R6: An upper compare byte of 0 gives a match after 65536 ticks.
- R7: `irqPulse` lasts exactly one system clock cycle per match.
- R8: `doneFlag` is set by a match and stays set until a cycle with `flagClr` = 1. When a match and `flagClr` fall on the same edge, the flag stays set.
- R9: Dropping `runEn` to 0 clears `countOut` to 0 on the next edge. Raising it again restarts counting from 0.
- R10: `wavePin` stays 0 at all times in this mode.
- R11: After a match, the counter keeps running from 0 while `runEn` stays 1, and the next match follows after another full period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| runEn | input | 1 | Run control: 1 counts, 0 stops and clears |
| srcTick | input | 1 | One-cycle enable per source clock period |
| cmpWrEn | input | 1 | Load strobe for the compare value |
| cmpWrData | input | 16 | Compare value; only bits 15:8 are used |
| flagClr | input | 1 | Write-one strobe that clears `doneFlag` |
| irqPulse | output | 1 | One-cycle interrupt request on a match |
| doneFlag | output | 1 | Sticky match status |
| wavePin | output | 1 | Timer waveform output, held inactive |
| countOut | output | 16 | Current 16-bit count |

## Verification
A broken carry between the two stages is visible on `countOut` within 256 ticks: the upper byte either fails to advance or advances too early. A stale comparison moves the first `irqPulse` off its expected tick count, which the bench measures to the exact cycle. A control fault, such as a clear that is ignored or a wrong priority between set and clear on the flag, shows on `countOut` or `doneFlag` one cycle after the stimulus.

// File: rtl/osc_settle_pkg.sv
package osc_settle_pkg;
  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic clear;  // force every stage to zero
    logic step;   // advance the chained counter by one
    logic load;   // capture a new compare value
  } settle_strobe_t;
endpackage

// File: rtl/osc_settle_datapath.sv
module osc_settle_datapath
  import osc_settle_pkg::*;
#(
  parameter int STAGE_W    = 8,
  parameter int NUM_STAGES = 2,
  localparam int CNT_W     = STAGE_W * NUM_STAGES,
  localparam int TOP       = NUM_STAGES - 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  settle_strobe_t       strb,
  input  logic [CNT_W-1:0]     cmpData,
  output logic                 hit,
  output logic [CNT_W-1:0]     count
);

  logic [STAGE_W-1:0] stageQ   [NUM_STAGES];
  logic [NUM_STAGES:0] carryIn;
  logic [STAGE_W-1:0] cmpHi;
  logic [STAGE_W-1:0] topNext;

  // Only the top stage of the compare word is stored; the rest never matters
  always_ff @(posedge clk) begin
    if (!rstN)          cmpHi <= '0;
    else if (strb.load) cmpHi <= cmpData[CNT_W-1 -: STAGE_W];
  end

  assign carryIn[0] = strb.step;
  assign topNext    = stageQ[TOP] + STAGE_W'(1);
  // Top stage about to reach the compare byte; the lower stages roll to zero then
  assign hit = carryIn[TOP] && (topNext == cmpHi);

  for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
    assign carryIn[i+1] = carryIn[i] && (stageQ[i] == {STAGE_W{1'b1}});
    assign count[i*STAGE_W +: STAGE_W] = stageQ[i];

    always_ff @(posedge clk) begin
      if (!rstN || strb.clear || hit) stageQ[i] <= '0;
      else if (carryIn[i])            stageQ[i] <= stageQ[i] + STAGE_W'(1);
    end
  end

  a_r2_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (count == '0));
  a_r3_step_one: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && !strb.clear && !hit) |=> (count == $past(count) + CNT_W'(1)));
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.step && !strb.clear) |=> $stable(count));
  a_r4_hit_clears: assert property (@(posedge clk) disable iff (!rstN)
    (hit && !strb.clear) |=> (count == '0));

endmodule

// File: rtl/osc_settle_ctrl.sv
module osc_settle_ctrl
  import osc_settle_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           runEn,
  input  logic           srcTick,
  input  logic           cmpWrEn,
  input  logic           flagClr,
  input  logic           hit,
  output settle_strobe_t strb,
  output logic           irqPulse,
  output logic           doneFlag
);

  always_comb begin
    strb.clear = !runEn;
    strb.step  = runEn && srcTick;
    strb.load  = cmpWrEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqPulse <= 1'b0;
      doneFlag <= 1'b0;
    end else begin
      irqPulse <= hit;
      // a new match outranks a simultaneous clear
      if (hit)          doneFlag <= 1'b1;
      else if (flagClr) doneFlag <= 1'b0;
    end
  end

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse);
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag && !flagClr) |=> doneFlag);
  a_r8_flag_follows_irq: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> doneFlag);

endmodule

// File: rtl/osc_settle_top.sv
module osc_settle_top
  import osc_settle_pkg::*;
#(
  parameter int STAGE_W    = 8,
  parameter int NUM_STAGES = 2,
  localparam int CNT_W     = STAGE_W * NUM_STAGES
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEn,
  input  logic             srcTick,
  input  logic             cmpWrEn,
  input  logic [CNT_W-1:0] cmpWrData,
  input  logic             flagClr,
  output logic             irqPulse,
  output logic             doneFlag,
  output logic             wavePin,
  output logic [CNT_W-1:0] countOut
);

  settle_strobe_t strb;
  logic           hit;

  osc_settle_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .runEn(runEn), .srcTick(srcTick),
    .cmpWrEn(cmpWrEn), .flagClr(flagClr), .hit(hit),
    .strb(strb), .irqPulse(irqPulse), .doneFlag(doneFlag)
  );

  osc_settle_datapath #(.STAGE_W(STAGE_W), .NUM_STAGES(NUM_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cmpData(cmpWrData),
    .hit(hit), .count(countOut)
  );

  // The waveform flip-flop stays cleared in settling mode so no pulse escapes
  assign wavePin = 1'b0;

  a_r4_irq_count_zero: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> (countOut == '0));
  a_r9_stop_clears: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> (countOut == '0));

endmodule

// File: tb/sim_osc_settle_top.sv
module sim_osc_settle_top;
  logic        clk = 1'b0;
  logic        rstN, runEn, srcTick, cmpWrEn, flagClr;
  logic [15:0] cmpWrData;
  logic        irqPulse, doneFlag, wavePin;
  logic [15:0] countOut;
  int          nChecks = 0;
  int          nFails  = 0;
  int          cycles  = 0;

  always #5 clk = ~clk;

  osc_settle_top u0 (
    .clk(clk), .rstN(rstN), .runEn(runEn), .srcTick(srcTick),
    .cmpWrEn(cmpWrEn), .cmpWrData(cmpWrData), .flagClr(flagClr),
    .irqPulse(irqPulse), .doneFlag(doneFlag), .wavePin(wavePin),
    .countOut(countOut)
  );

  // compare values and ticks until the match
  localparam int NVEC = 5;
  localparam logic [15:0] VEC_CMP [NVEC] = '{16'h0100, 16'h02A7, 16'h03FF, 16'h0500, 16'h0000};
  localparam int          VEC_EXP [NVEC] = '{256, 512, 768, 1280, 65536};
  localparam string       VEC_TAG [NVEC] = '{"R4", "R5", "R5", "R4", "R6"};

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      finishRun();
    end
  end

  task automatic writeCmp(input logic [15:0] v);
    cmpWrData = v; cmpWrEn = 1'b1;
    @(negedge clk);
    cmpWrEn = 1'b0;
  endtask

  // count cycles from start until irqPulse; returns the count
  task automatic waitIrq(input int limit, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!irqPulse && n < limit);
  endtask

  initial begin
    int n;
    rstN = 1'b0; runEn = 1'b0; srcTick = 1'b0; cmpWrEn = 1'b0;
    flagClr = 1'b0; cmpWrData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(irqPulse == 0, "R1 irq", irqPulse, 0);
    check(doneFlag == 0, "R1 flag", doneFlag, 0);
    check(countOut == 0, "R1 count", countOut, 0);
    check(wavePin == 0, "R1 wave", wavePin, 0);

    // R2 ticks ignored while stopped
    srcTick = 1'b1;
    repeat (6) @(negedge clk);
    check(countOut == 0, "R2 stopped", countOut, 0);

    // R3 sparse ticks: one tick every third cycle
    writeCmp(16'h0100);
    srcTick = 1'b0; runEn = 1'b1;
    for (int k = 0; k < 10; k++) begin
      srcTick = 1'b1; @(negedge clk);
      srcTick = 1'b0; @(negedge clk); @(negedge clk);
    end
    check(countOut == 10, "R3 sparse", countOut, 10);
    @(negedge clk);
    check(countOut == 10, "R3 hold", countOut, 10);

    // R9 stop clears, restart from zero
    runEn = 1'b0; @(negedge clk);
    check(countOut == 0, "R9 stop", countOut, 0);
    runEn = 1'b1; srcTick = 1'b1;
    repeat (3) @(negedge clk);
    check(countOut == 3, "R9 restart", countOut, 3);
    runEn = 1'b0; @(negedge clk);

    // vector table walk
    for (int v = 0; v < NVEC; v++) begin
      writeCmp(VEC_CMP[v]);
      flagClr = 1'b1; @(negedge clk); flagClr = 1'b0;
      check(doneFlag == 0, "R8 cleared", doneFlag, 0);
      srcTick = 1'b1; runEn = 1'b1;
      waitIrq(VEC_EXP[v] + 16, n);
      check(n == VEC_EXP[v], VEC_TAG[v], n, VEC_EXP[v]);
      check(countOut == 0, "R4 count at irq", countOut, 0);
      check(wavePin == 0, "R10 wave", wavePin, 0);
      @(negedge clk);
      check(irqPulse == 0, "R7 one cycle", irqPulse, 0);
      check(doneFlag == 1, "R8 set", doneFlag, 1);
      if (v == 0) begin
        // R11 second period, one tick already taken after the match
        waitIrq(300, n);
        check(n == 255, "R11 repeat", n, 255);
      end
      runEn = 1'b0; @(negedge clk);
    end

    // R8 clear and match on the same edge: set wins
    writeCmp(16'h0100);
    runEn = 1'b1; srcTick = 1'b1;
    repeat (255) @(negedge clk);
    check(irqPulse == 0, "R4 early", irqPulse, 0);
    flagClr = 1'b1; @(negedge clk); flagClr = 1'b0;
    check(irqPulse == 1, "R4 on time", irqPulse, 1);
    check(doneFlag == 1, "R8 set beats clear", doneFlag, 1);
    runEn = 1'b0; @(negedge clk);
    check(wavePin == 0, "R10 end", wavePin, 0);

    finishRun();
  end
endmodule